// File: doc/BRIEF.md
# Half-Duplex Boot Flash SPI Master

This block is a SPI master that a processor drives through three registers to reach a boot NOR flash. Each data access moves data in one direction only. A data-register write shifts bytes out. A data-register read shifts bytes in and holds the bus response until the last byte has arrived. Software selects the transfer size of one or four bytes. It drives both active-low chip-select pins by writing bits of the control/status register, and it polls a ready flag before each data access.

The shift engine runs SPI mode 0 and sends the most significant bit first. The serial clock is the system clock divided by the even parameter `CLK_DIV`. Two configuration bits pick the byte order of four-byte words, one bit for reads and one for writes. Single bytes always travel in the top byte lane of the data register.

Top module: `nor_boot_spi_ctrl`

## Requirements
- R1: After reset both chip-select outputs are high and SCLK is low. The control/status register (offset 0x8) reads 0xC800_0000: chip selects deasserted, length one byte, ready set. The configuration register (offset 0x0) reads 0.
- R2: Bit 31 of the control/status register drives `spi_cs0_n` and bit 30 drives `spi_cs1_n`. Both are written by software and read back unchanged. Configuration bit 28 (read order) and bit 27 (write order) are readable and writable. Unmapped offsets read 0.
- R3: Control/status bits 29:28 set the length. The code 11 gives a four-byte transfer of 32 SCLK pulses. Any other code, including 00, gives a one-byte transfer of 8 pulses.
- R4: SCLK idles low. MOSI changes only while SCLK is low, and MISO is sampled on the SCLK rising edge, MSB first. The SCLK period is `CLK_DIV` system clocks.
- R5: A one-byte write to the data register (offset 0xC) sends bits 31:24. A one-byte read returns the received byte in bits 31:24, with bits 23:0 at zero.
- R6: A four-byte write with configuration bit 27 set sends bits 31:24 first, then 23:16, 15:8 and 7:0. With bit 27 clear the order is reversed, starting with bits 7:0.
- R7: A four-byte read with configuration bit 28 set places the first received byte in bits 31:24. With bit 28 clear the first received byte goes to bits 7:0, and the later bytes fill the higher lanes in turn.
- R8: A data-register read holds `bus_ack` low until every programmed byte has been received. MOSI stays low during the receive.
- R9: Control/status bit 27 reads 0 while a transfer is in progress and 1 when the engine is idle.
- R10: A data-register write that arrives while a transfer is in progress is acknowledged but ignored. It adds no SCLK pulses and leaves the bits being sent unchanged.
- R11: `bus_ack` is a one-cycle pulse. Writes and reads of registers other than the data register are acknowledged on the clock edge after the request is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Request valid, held until `bus_ack` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle completion pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs0_n | output | 1 | Flash chip select 0, active low |
| spi_cs1_n | output | 1 | Chip select 1, active low, normally kept high |

## Verification
A wrong length, bit counter or divider state shows up at once on the pins: the SCLK pulse count and period seen by the slave model within the same transfer are off. A wrong byte order or lane placement appears in the captured MOSI word, or in the read data on the single `bus_ack` that ends the access. A stuck busy or pending state shows first as a ready flag that never returns, or as an acknowledge that never comes. The bench catches both through its poll and its watchdog.

// File: rtl/nbs_pkg.sv
// Package: shared constants for the boot flash SPI master.
// Assumes a 32-bit register bus with a 4-bit byte offset.
package nbs_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int ADDR_W = 4;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_CFG  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CSR  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_DATA = 4'hC;

    // bit positions inside the control/status register
    localparam int CSR_CS0_BIT = 31;
    localparam int CSR_CS1_BIT = 30;
    localparam int CSR_LEN_HI  = 29;
    localparam int CSR_LEN_LO  = 28;
    localparam int CSR_RDY_BIT = 27;

    // bit positions inside the configuration register
    localparam int CFG_RD_ORDER_BIT = 28;
    localparam int CFG_WR_ORDER_BIT = 27;

    // lowest register bit carried into the register file
    localparam int CTL_LSB = 27;
    localparam int CTL_W   = WORD_W - CTL_LSB;

    localparam logic [1:0] LEN_QUAD = 2'b11;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CFG,
        ACC_CSR,
        ACC_DATA
    } acc_sel_e;

    // Map a byte offset onto the register it selects.
    function automatic acc_sel_e decode_offset(input logic [ADDR_W-1:0] ofs);
        acc_sel_e sel;
        unique case (ofs)
            OFS_CFG:  sel = ACC_CFG;
            OFS_CSR:  sel = ACC_CSR;
            OFS_DATA: sel = ACC_DATA;
            default:  sel = ACC_NONE;
        endcase
        return sel;
    endfunction
endpackage

// File: rtl/nbs_lane_order.sv
// Module: nbs_lane_order
// Reverses the byte lanes of a word when swap is set and passes the word
// through otherwise. Purely combinational. Assumes WORD_W is a multiple of 8.
module nbs_lane_order #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [WORD_W-1:0] in_word,
    input  logic              swap,
    output logic [WORD_W-1:0] out_word
);
    localparam int LANES = WORD_W / BYTE_W;

    logic [WORD_W-1:0] reversed;

    // one lane mapping per byte position
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign reversed[g*BYTE_W +: BYTE_W] = in_word[(LANES-1-g)*BYTE_W +: BYTE_W];
    end

    // choose the reversed or the straight word
    assign out_word = swap ? reversed : in_word;
endmodule

// File: rtl/nbs_regfile.sv
// Module: nbs_regfile
// Holds the configuration register (read/write order bits) and the
// control/status register (two chip selects, length field). Provides the
// read value for both, with the ready flag taken live from the shift engine.
// Assumes only bits 31:27 of a write word are meaningful and that the top
// level has already decoded the offset.
module nbs_regfile
    import nbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  acc_sel_e          sel,
    input  logic [CTL_W-1:0]  wr_bits,
    input  logic              eng_busy,
    output logic [WORD_W-1:0] rd_data,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic              len_quad,
    output logic              rd_order_be,
    output logic              wr_order_be
);
    localparam int CS0_I = CSR_CS0_BIT - CTL_LSB;
    localparam int CS1_I = CSR_CS1_BIT - CTL_LSB;
    localparam int LHI_I = CSR_LEN_HI - CTL_LSB;
    localparam int LLO_I = CSR_LEN_LO - CTL_LSB;
    localparam int RDO_I = CFG_RD_ORDER_BIT - CTL_LSB;
    localparam int WRO_I = CFG_WR_ORDER_BIT - CTL_LSB;

    logic       cs0_q, cs1_q;
    logic [1:0] len_q;
    logic       rdo_q, wro_q;

    // control/status register: chip selects and length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs0_q <= 1'b1;
            cs1_q <= 1'b1;
            len_q <= 2'b00;
        end else if (wr_en && sel == ACC_CSR) begin
            cs0_q <= wr_bits[CS0_I];
            cs1_q <= wr_bits[CS1_I];
            len_q <= {wr_bits[LHI_I], wr_bits[LLO_I]};
        end
    end

    // configuration register: byte order for each direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdo_q <= 1'b0;
            wro_q <= 1'b0;
        end else if (wr_en && sel == ACC_CFG) begin
            rdo_q <= wr_bits[RDO_I];
            wro_q <= wr_bits[WRO_I];
        end
    end

    // read mux over the two registers
    always_comb begin
        rd_data = '0;
        unique case (sel)
            ACC_CFG: begin
                rd_data[CFG_RD_ORDER_BIT] = rdo_q;
                rd_data[CFG_WR_ORDER_BIT] = wro_q;
            end
            ACC_CSR: begin
                rd_data[CSR_CS0_BIT]                = cs0_q;
                rd_data[CSR_CS1_BIT]                = cs1_q;
                rd_data[CSR_LEN_HI:CSR_LEN_LO]      = len_q;
                rd_data[CSR_RDY_BIT]                = !eng_busy;
            end
            default: rd_data = '0;
        endcase
    end

    assign cs0_n       = cs0_q;
    assign cs1_n       = cs1_q;
    assign len_quad    = (len_q == LEN_QUAD);
    assign rd_order_be = rdo_q;
    assign wr_order_be = wro_q;

    // a write to the other registers must leave chip select 0 alone
    AST_CS0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == ACC_CSR) |=> $stable(cs0_q)); // R2
endmodule

// File: rtl/nbs_shifter.sv
// Module: nbs_shifter
// SPI mode 0 shift engine, MSB first. On start it loads a 32-bit word and
// shifts 8 or 32 bits. In transmit mode it drives MOSI from the top of the
// shift register and shifts in zeros. In receive mode it holds MOSI low and
// samples MISO on each SCLK rising edge. Assumes CLK_DIV is even and at
// least 2, and that start is pulsed only while busy is low.
module nbs_shifter #(
    parameter int WORD_W  = 32,
    parameter int BYTE_W  = 8,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_tx,
    input  logic              quad,
    input  logic [WORD_W-1:0] load_word,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);
    localparam logic [BIT_W-1:0] BITS_QUAD = BIT_W'(WORD_W - 1);
    localparam logic [BIT_W-1:0] BITS_ONE  = BIT_W'(BYTE_W - 1);

    logic              busy_q, done_q, sclk_q, samp_q, tx_q;
    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bit_q;
    logic [WORD_W-1:0] sh_q;
    logic              phase_end;

    // end of the current half period of SCLK
    assign phase_end = (div_q == DIV_LAST);

    // transfer sequencing, SCLK generation and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            sclk_q <= 1'b0;
            samp_q <= 1'b0;
            tx_q   <= 1'b0;
            div_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                tx_q   <= start_tx;
                sh_q   <= start_tx ? load_word : '0;
                bit_q  <= quad ? BITS_QUAD : BITS_ONE;
                div_q  <= '0;
                sclk_q <= 1'b0;
            end else if (busy_q) begin
                if (phase_end) begin
                    div_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        samp_q <= miso;
                    end else begin
                        sclk_q <= 1'b0;
                        sh_q   <= {sh_q[WORD_W-2:0], tx_q ? 1'b0 : samp_q};
                        if (bit_q == '0) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_q <= bit_q - 1'b1;
                        end
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign sclk    = sclk_q;
    assign mosi    = busy_q && tx_q && sh_q[WORD_W-1];
    assign rx_word = sh_q;

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q); // R10
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q); // R4
    AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !$stable(sclk_q)) |-> $past(phase_end)); // R4
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q))); // R9
endmodule

// File: rtl/nor_boot_spi_ctrl.sv
// Module: nor_boot_spi_ctrl (top)
// Register-mapped half-duplex SPI master for a boot NOR flash. It decodes
// bus requests, starts a transmit on a data write and a receive on a data
// read, and holds the acknowledge of a data read until the engine finishes.
// Assumes the bus master holds a request stable until bus_ack and drops it
// in the cycle after the acknowledge.
module nor_boot_spi_ctrl
    import nbs_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs0_n,
    output logic              spi_cs1_n
);
    acc_sel_e          acc_sel;
    logic              accept, reg_wr, start_tx, start_rx, eng_start;
    logic              ack_q, rd_pend_q, rd_run_q;
    logic [WORD_W-1:0] rdata_q;
    logic [WORD_W-1:0] reg_rdata, tx_ordered, tx_load, rx_ordered, rx_final;
    logic              len_quad, rd_order_be, wr_order_be;
    logic              eng_busy, eng_done, eng_mosi;
    logic [WORD_W-1:0] eng_word;

    // request decode and start conditions
    assign acc_sel   = decode_offset(bus_addr);
    assign accept    = bus_sel && !ack_q && !rd_pend_q;
    assign reg_wr    = accept && bus_we && (acc_sel == ACC_CFG || acc_sel == ACC_CSR);
    assign start_tx  = accept && bus_we && (acc_sel == ACC_DATA) && !eng_busy;
    assign start_rx  = rd_pend_q && !rd_run_q && !eng_busy;
    assign eng_start = start_tx || start_rx;

    nbs_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .sel        (acc_sel),
        .wr_bits    (bus_wdata[WORD_W-1:CTL_LSB]),
        .eng_busy   (eng_busy),
        .rd_data    (reg_rdata),
        .cs0_n      (spi_cs0_n),
        .cs1_n      (spi_cs1_n),
        .len_quad   (len_quad),
        .rd_order_be(rd_order_be),
        .wr_order_be(wr_order_be)
    );

    // transmit ordering: the engine always sends bit 31 first
    nbs_lane_order #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_tx_order (
        .in_word (bus_wdata),
        .swap    (!wr_order_be),
        .out_word(tx_ordered)
    );
    assign tx_load = len_quad ? tx_ordered : bus_wdata;

    // receive ordering: the engine leaves the first byte in bits 31:24
    nbs_lane_order #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_rx_order (
        .in_word (eng_word),
        .swap    (!rd_order_be),
        .out_word(rx_ordered)
    );
    assign rx_final = len_quad ? rx_ordered
                               : {eng_word[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};

    nbs_shifter #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .CLK_DIV(CLK_DIV)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .start_tx (start_tx),
        .quad     (len_quad),
        .load_word(tx_load),
        .miso     (spi_miso),
        .busy     (eng_busy),
        .done     (eng_done),
        .sclk     (spi_sclk),
        .mosi     (eng_mosi),
        .rx_word  (eng_word)
    );

    // bus response: acknowledge pulse, read data and the pending data read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q     <= 1'b0;
            rdata_q   <= '0;
            rd_pend_q <= 1'b0;
            rd_run_q  <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (accept) begin
                if (bus_we) begin
                    ack_q <= 1'b1;
                end else if (acc_sel == ACC_DATA) begin
                    rd_pend_q <= 1'b1;
                    rd_run_q  <= 1'b0;
                end else begin
                    ack_q   <= 1'b1;
                    rdata_q <= reg_rdata;
                end
            end
            if (start_rx) begin
                rd_run_q <= 1'b1;
            end
            if (rd_pend_q && rd_run_q && eng_done) begin
                ack_q     <= 1'b1;
                rdata_q   <= rx_final;
                rd_pend_q <= 1'b0;
                rd_run_q  <= 1'b0;
            end
        end
    end

    assign bus_ack   = ack_q;
    assign bus_rdata = rdata_q;
    assign spi_mosi  = eng_mosi;

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack); // R11
    AST_RX_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_run_q |-> !spi_mosi); // R8
    AST_NO_ACK_MID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend_q && eng_busy) |-> !bus_ack); // R8
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R4
endmodule

// File: tb/nor_boot_spi_ctrl_tb_top.sv
// Directed bench for nor_boot_spi_ctrl with a mode 0 flash slave model.
module nor_boot_spi_ctrl_tb_top;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic        spi_sclk, spi_mosi, spi_miso, spi_cs0_n, spi_cs1_n;

    int checks = 0;
    int failures = 0;
    bit timed_out = 0;

    always #2 clk = ~clk;

    nor_boot_spi_ctrl #(.CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs0_n(spi_cs0_n), .spi_cs1_n(spi_cs1_n)
    );

    // slave model: clock counter, MOSI capture on rise, MISO change on fall
    int          cyc = 0;
    int          rise_cnt = 0;
    int          fall_cnt = 0;
    int          last_rise = 0;
    int          rise_period = 0;
    logic [63:0] mosi_log = '0;
    int          fall_base = 0;
    logic [31:0] slave_word = '0;
    int          idx;

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge spi_sclk) begin
        mosi_log    = {mosi_log[62:0], spi_mosi};
        rise_period = cyc - last_rise;
        last_rise   = cyc;
        rise_cnt    = rise_cnt + 1;
    end
    always @(negedge spi_sclk) fall_cnt = fall_cnt + 1;
    always_comb begin
        idx      = fall_cnt - fall_base;
        spi_miso = (idx >= 0 && idx < 32) ? slave_word[31 - idx] : 1'b0;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_xfer(input bit we, input logic [3:0] a, input logic [31:0] d,
                            output logic [31:0] rd, output int ncyc);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        ncyc = 0;
        do begin
            @(negedge clk);
            ncyc++;
        end while (!bus_ack);
        rd = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        logic [31:0] rd; int n;
        bus_xfer(1'b1, a, d, rd, n);
    endtask

    task automatic wait_idle();
        logic [31:0] rd; int n;
        do bus_xfer(1'b0, 4'h8, 32'h0, rd, n); while (!rd[27]);
    endtask

    task automatic t_reset();
        logic [31:0] rd; int n;
        check(spi_cs0_n && spi_cs1_n && !spi_sclk, "R1 pins",
              {29'b0, spi_cs0_n, spi_cs1_n, spi_sclk}, 32'h6);
        bus_xfer(1'b0, 4'h8, 0, rd, n);
        check(rd == 32'hC800_0000, "R1 csr", rd, 32'hC800_0000);
        check(n == 1, "R11 read ack", n, 1);
        bus_xfer(1'b0, 4'h0, 0, rd, n);
        check(rd == 32'h0, "R1 cfg", rd, 0);
        bus_xfer(1'b0, 4'h4, 0, rd, n);
        check(rd == 32'h0, "R2 unmapped", rd, 0);
    endtask

    task automatic t_chip_select();
        logic [31:0] rd; int n;
        bus_xfer(1'b1, 4'h8, 32'h8000_0000, rd, n);
        check(n == 1, "R11 write ack", n, 1);
        check(spi_cs0_n && !spi_cs1_n, "R2 cs1 pin", {30'b0, spi_cs0_n, spi_cs1_n}, 2);
        wr(4'h8, 32'h4000_0000);
        check(!spi_cs0_n && spi_cs1_n, "R2 cs0 pin", {30'b0, spi_cs0_n, spi_cs1_n}, 1);
        bus_xfer(1'b0, 4'h8, 0, rd, n);
        check(rd == 32'h4800_0000, "R2 csr readback", rd, 32'h4800_0000);
        wr(4'h0, 32'h1800_0000);
        bus_xfer(1'b0, 4'h0, 0, rd, n);
        check(rd == 32'h1800_0000, "R2 cfg readback", rd, 32'h1800_0000);
    endtask

    task automatic t_tx_one();
        int base;
        wr(4'h8, 32'h4000_0000);
        base = rise_cnt;
        wr(4'hC, 32'h9C12_3456);
        wait_idle();
        check(rise_cnt - base == 8, "R3 one-byte pulses", rise_cnt - base, 8);
        check(mosi_log[7:0] == 8'h9C, "R5 one-byte tx", {24'b0, mosi_log[7:0]}, 32'h9C);
        check(rise_period == DIV, "R4 sclk period", rise_period, DIV);
    endtask

    task automatic t_tx_quad(input bit be, input logic [31:0] exp);
        int base;
        wr(4'h0, be ? 32'h0800_0000 : 32'h0);
        wr(4'h8, 32'h7000_0000);
        base = rise_cnt;
        wr(4'hC, 32'h1122_3344);
        wait_idle();
        check(rise_cnt - base == 32, "R3 four-byte pulses", rise_cnt - base, 32);
        check(mosi_log[31:0] == exp, "R6 write order", mosi_log[31:0], exp);
        check(!spi_sclk, "R4 sclk idle low", {31'b0, spi_sclk}, 0);
    endtask

    task automatic t_rx_one();
        logic [31:0] rd; int n;
        wr(4'h8, 32'h4000_0000);
        slave_word = 32'h5AFF_FFFF;
        fall_base = fall_cnt;
        bus_xfer(1'b0, 4'hC, 0, rd, n);
        check(rd == 32'h5A00_0000, "R5 one-byte rx", rd, 32'h5A00_0000);
        check(n >= 8 * DIV && n < 32 * DIV, "R3 one-byte read length", n, 8 * DIV);
    endtask

    task automatic t_rx_quad(input bit be, input logic [31:0] exp);
        logic [31:0] rd; int n;
        wr(4'h0, be ? 32'h1000_0000 : 32'h0);
        wr(4'h8, 32'h7000_0000);
        slave_word = 32'hA1B2_C3D4;
        fall_base = fall_cnt;
        bus_xfer(1'b0, 4'hC, 0, rd, n);
        check(rd == exp, "R7 read order", rd, exp);
        check(n >= 32 * DIV, "R8 read stall", n, 32 * DIV);
        check(mosi_log[31:0] == 32'h0, "R8 mosi low on rx", mosi_log[31:0], 0);
    endtask

    task automatic t_busy_write();
        logic [31:0] rd; int n, base;
        wr(4'h0, 32'h0800_0000);
        wr(4'h8, 32'h7000_0000);
        base = rise_cnt;
        wr(4'hC, 32'hAABB_CCDD);
        bus_xfer(1'b0, 4'h8, 0, rd, n);
        check(rd[27] == 1'b0, "R9 ready low while busy", rd, 32'h7000_0000);
        wr(4'hC, 32'h0F0F_0F0F);
        wait_idle();
        bus_xfer(1'b0, 4'h8, 0, rd, n);
        check(rd[27] == 1'b1, "R9 ready high when idle", rd, 32'h7800_0000);
        check(rise_cnt - base == 32, "R10 no extra pulses", rise_cnt - base, 32);
        check(mosi_log[31:0] == 32'hAABB_CCDD, "R10 data unchanged",
              mosi_log[31:0], 32'hAABB_CCDD);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_chip_select();
                t_tx_one();
                t_tx_quad(1'b1, 32'h1122_3344);
                t_tx_quad(1'b0, 32'h4433_2211);
                t_rx_one();
                t_rx_quad(1'b1, 32'hA1B2_C3D4);
                t_rx_quad(1'b0, 32'hD4C3_B2A1);
                t_busy_write();
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule